// File: doc/BRIEF.md
# Pipelined synchronous SRAM model

This block is a synthesizable behavioural model of a synchronous static RAM with registers on both sides of the array. Address, write data and three active-low controls (chip enable, write enable, output enable) are captured on each rising clock edge. On the following edge the captured controls are decoded into a read, a write or a deselect. Read data is loaded into an output register and placed on a shared bidirectional data bus. Write data is taken from that same bus.

The bus driver is switched by registered state, so a deselect releases the bus one cycle later rather than at once. The one exception is the raw write-enable pin: while it is low, the driver is switched off at once, so the model never fights with data that an external master is driving for a write. A status output reports a power-down condition whenever the captured chip enable is high. Address width and data width are parameters. The default is a 1024-word by 9-bit array; setting the address width to 18 gives the 262144-word organization.

Top module: `sync_sram_pipe`

## Requirements
- R1: With ce_n=0, oe_n=0 and we_n=1 sampled at edge k (a read), the word at the sampled address is on dq and drv_active=1 after edge k+1, for as long as the we_n pin stays 1 until edge k+2.
- R2: With ce_n=0 and we_n=0 sampled at edge k (a write), the dq value sampled at edge k is stored at the sampled address, whatever the level of oe_n.
- R3: With ce_n=1, or with oe_n=1 and we_n=1, sampled at edge k (a deselect), the array is not written, even if we_n is low and dq carries data. drv_active=0 and dq is released after edge k+1.
- R4: The driver is off (drv_active=0) whenever the we_n pin is low. It is also off in the cycle after edge k+1 when a write was sampled at edge k.
- R5: pwr_down is 1 after any edge that sampled ce_n=1. It is 0 after any edge that sampled ce_n=0. A deselect caused by oe_n=1 and we_n=1 leaves pwr_down at 0.
- R6: While rst_n=0, drv_active=0, pwr_down=1 and the output register is cleared.
- R7: Reads of different addresses sampled on consecutive edges each return their own word, exactly one edge after the edge that sampled them.
- R8: A read sampled on the edge after a write to the same address returns the newly written word.
- R9: Every address up to 2^ADDR_W-1 can be written and read back, and every bit of the data width is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, sampled each edge |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| dq | inout | DATA_W | Shared data bus: write data in, read data out |
| drv_active | output | 1 | High while the model drives dq |
| pwr_down | output | 1 | High while the captured chip enable is inactive |

## Verification
The assertions take for granted that all inputs change only away from the rising edge. They also assume that the external master drives dq only while it holds we_n low, so any contention could only come from the model's side. The bench changes every input on the falling edge and drives dq exactly when the we_n it presents is low. A scoreboard predicts the bus from the sequence of operations. It only reads addresses that were written earlier in the run, so it never depends on the array's contents before any write.

// File: rtl/sync_sram_pipe.sv
module sync_sram_pipe #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  inout  wire  [DATA_W-1:0] dq,
  output logic              drv_active,
  output logic              pwr_down
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic              ce_q, we_q, oe_q;
  logic [DATA_W-1:0] dout;
  logic              drv_q;
  logic              rd_cyc, wr_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      d_q  <= '0;
      ce_q <= 1'b1;
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      a_q  <= addr;
      d_q  <= dq;
      ce_q <= ce_n;
      we_q <= we_n;
      oe_q <= oe_n;
    end
  end

  assign rd_cyc = !ce_q && we_q && !oe_q;
  assign wr_cyc = !ce_q && !we_q;

  always_ff @(posedge clk) begin
    if (wr_cyc) mem[a_q] <= d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      drv_q <= 1'b0;
    end else begin
      if (rd_cyc) dout <= mem[a_q];
      drv_q <= rd_cyc;
    end
  end

  assign drv_active = drv_q && we_n;
  assign dq         = drv_active ? dout : {DATA_W{1'bz}};
  assign pwr_down   = ce_q;

  assert_desel_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || (oe_n && we_n)) |=> ##1 !drv_q);

  assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> ##1 !drv_active);

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n) |=> ##1 (!we_n || drv_active));

  assert_pd_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> pwr_down);

  assert_pd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |=> !pwr_down);

  assert_reset_quiet_R6: assert property (@(posedge clk)
    !rst_n |-> (!drv_active && pwr_down && dout == '0));

endmodule

// File: tb/test_sync_sram_pipe.sv
module test_sync_sram_pipe;
  localparam int AW = 10;
  localparam int DW = 9;

  typedef struct {
    logic          ce, we, oe;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         tag;
  } op_t;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic tb_drv = 1'b0;
  logic [DW-1:0] tb_dq = '0;
  wire  [DW-1:0] dq;
  logic drv_active, pwr_down;

  int tests = 0, fails = 0;
  op_t q[$];
  logic [DW-1:0] refmem [1 << AW];

  assign dq = tb_drv ? tb_dq : {DW{1'bz}};

  always #4 clk = ~clk;

  sync_sram_pipe #(.ADDR_W(AW), .DATA_W(DW)) i_sync_sram_pipe (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .dq(dq), .drv_active(drv_active), .pwr_down(pwr_down));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic c, logic w, logic o, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    op_t t;
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; addr = a;
    tb_dq = d; tb_drv = !w;
    t.ce = c; t.we = w; t.oe = o; t.a = a; t.d = d; t.tag = tag;
    q.push_back(t);
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);   drive(0, 1, 0, a, '0, tag); endtask
  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, string tag); drive(0, 0, 0, a, d, tag); endtask
  task automatic idle(string tag);                    drive(1, 1, 1, '0, '0, tag); endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin : monitor
    op_t prev, cur;
    bit have_prev = 0;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() == 0) continue;
      cur = q.pop_front();
      check(cur.tag, {31'd0, pwr_down}, {31'd0, cur.ce}, "pwr_down (R5)");
      if (have_prev && !prev.ce && prev.we && !prev.oe) begin
        check(prev.tag, {31'd0, drv_active}, {31'd0, cur.we}, "drv_active after read");
        if (cur.we) check(prev.tag, {23'd0, dq}, {23'd0, refmem[prev.a]}, "read data");
      end else begin
        check(have_prev ? prev.tag : cur.tag, {31'd0, drv_active}, 32'd0, "drv_active idle (R3/R4)");
      end
      if (have_prev && !prev.ce && !prev.we) refmem[prev.a] = prev.d;
      prev = cur;
      have_prev = 1;
    end
  end

  initial begin : watchdog
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    #1 rst_n = 1'b0;
    #20;
    check("R6", {31'd0, drv_active}, 32'd0, "drv_active in reset");
    check("R6", {31'd0, pwr_down}, 32'd1, "pwr_down in reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R5");
    idle("R5");
    for (int i = 0; i < 8; i++) wr(AW'(i), DW'(9'h0A5 ^ (i * 37)), "R2");
    drive(0, 0, 1, 10'd20, 9'h133, "R2");
    idle("R3");
    for (int i = 0; i < 8; i++) rd(AW'(i), "R7");
    rd(10'd20, "R2");
    wr(10'd40, 9'h1C3, "R8");
    rd(10'd40, "R8");
    drive(0, 1, 1, 10'd3, '0, "R3");
    drive(1, 0, 0, 10'd3, 9'h0FF, "R3");
    drive(1, 0, 1, 10'd4, 9'h111, "R3");
    rd(10'd3, "R3");
    rd(10'd4, "R3");
    rd(10'd5, "R4");
    wr(10'd6, 9'h155, "R4");
    rd(10'd6, "R4");
    wr(10'd1023, 9'h1FF, "R9");
    wr(10'd0, 9'h000, "R9");
    rd(10'd1023, "R9");
    rd(10'd0, "R9");
    drive(0, 1, 1, '0, '0, "R5");
    rd(10'd7, "R1");
    idle("R1");
    idle("R1");
    idle("R1");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule